// File: doc/BRIEF.md
# I/O Window Cycle Timing Controller

This block times accesses to a card's I/O space through two I/O windows, numbered 0 and 1. It holds one 8-bit control byte. Each window owns four of its bits. The bits choose where the transfer width comes from, the fixed width, a stretch for wide cycles and a shortening for narrow cycles. Software reads and writes the byte through a plain byte-wide port.

For each access the requester raises `start` for one clock, along with a window number and the card's live 16-bit indicator. The block then does four things:

- It resolves the transfer width.
- It latches the width and the cycle length.
- It holds `busy` for exactly as many clocks as the cycle lasts.
- It pulses `done` in the last busy clock.

Address matching, data steering and the card-side bus pins are outside this block.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. A `start` that arrives while `busy` is high is dropped; it is not queued.

Top module: `iowin_timer`

## Requirements
- R1: After reset the control byte reads 00h, and `busy`, `done` and `width16` are all 0.
- R2: Asserting `cfg_wr` for one clock stores all eight bits of `cfg_wdata`. From the next clock, `cfg_rdata` returns the whole stored byte.
- R3: Window 0 is controlled by bits 3:0 and window 1 by bits 7:4. Inside a window's nibble the bits are, from top to bottom: wide-cycle stretch, narrow-cycle shorten, width-source select, and fixed size. `win_sel` = 0 selects window 0.
- R4: When the width-source bit is 0, the fixed-size bit sets the width: 0 gives 8 bits (`width16` = 0) and 1 gives 16 bits (`width16` = 1).
- R5: When the width-source bit is 1, the fixed-size bit is ignored. The width equals `card_is16` as sampled on the accepted `start`. Later changes of `card_is16` do not alter `width16` or the length of that access.
- R6: An 8-bit cycle keeps `busy` high for LEN8 clocks (default 6). With the shorten bit set, it lasts LEN_ZW clocks (default 3).
- R7: A 16-bit cycle lasts LEN16 clocks (default 3). With the stretch bit set, it lasts LEN16+EXT clocks (default 4).
- R8: The stretch bit has no effect on 8-bit cycles, and the shorten bit has no effect on 16-bit cycles.
- R9: `busy` rises on the clock after an accepted `start`. `done` is high for exactly one clock, the last clock of `busy`, and `busy` is low on the clock after `done`.
- R10: A `start` while `busy` is high is ignored. The running access keeps its length, and no second access follows.
- R11: A write to the control byte during an access, or in the same clock as an accepted `start`, affects only later accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write value |
| cfg_rdata | output | 8 | Control byte read value |
| start | input | 1 | One-clock access request |
| win_sel | input | 1 | Window number for the request |
| card_is16 | input | 1 | Card's live 16-bit indicator |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock pulse in the last busy clock |
| width16 | output | 1 | Resolved width of the current/last access, 1 = 16 bits |

## Verification
The embedded properties watch, on every clock, four things:
- the byte read-back after a write;
- `done` staying inside `busy` and ending it;
- `busy` holding, with a stable width, until `done`;
- the length counter staying in range.

The per-window decode needs the bench's directed scenarios, which measure cycle length in clocks against the expected value for each combination of nibble bits. These cover:
- the nibble layout of both windows;
- the stretch and shorten bits applying only to their own width class;
- width taken from the card line versus the fixed bit;
- the mid-access cases: a card line toggling, a repeated start and a config write.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  localparam int NUM_WIN = 2;
  localparam int CTL_BITS = 4;
  localparam int CFG_W = NUM_WIN * CTL_BITS;

  typedef struct packed {
    logic ext16;     // stretch wide cycles
    logic zw8;       // shorten narrow cycles
    logic src_card;  // width from card line
    logic size16;    // fixed width when src_card = 0
  } win_ctl_t;
endpackage

// File: rtl/iowin_cfg_reg.sv
module iowin_cfg_reg
  import iowin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata;
  end

  // R2: a write is visible in full on the following clock
  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (q == $past(wdata)));
endmodule

// File: rtl/iowin_resolve.sv
module iowin_resolve
  import iowin_pkg::*;
#(
  parameter int LEN8   = 6,
  parameter int LEN16  = 3,
  parameter int LEN_ZW = 3,
  parameter int EXT    = 1,
  parameter int CW     = 3
) (
  input  win_ctl_t        ctl,
  input  logic            card_is16,
  output logic            wide,
  output logic [CW-1:0]   len
);
  localparam logic [CW-1:0] L8   = CW'(LEN8);
  localparam logic [CW-1:0] LZW  = CW'(LEN_ZW);
  localparam logic [CW-1:0] L16  = CW'(LEN16);
  localparam logic [CW-1:0] L16X = CW'(LEN16 + EXT);

  always_comb begin
    wide = ctl.src_card ? card_is16 : ctl.size16;
    if (wide) len = ctl.ext16 ? L16X : L16;
    else      len = ctl.zw8   ? LZW  : L8;
  end
endmodule

// File: rtl/iowin_cycle_ctr.sv
module iowin_cycle_ctr #(
  parameter int CW     = 3,
  parameter int MAXLEN = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len_in,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (load) begin
      cnt  <= len_in - 1'b1;
      busy <= 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  // R6 / R7: remaining count never exceeds the longest cycle
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < CW'(MAXLEN)));
endmodule

// File: rtl/iowin_timer.sv
module iowin_timer
  import iowin_pkg::*;
#(
  parameter int LEN8   = 6,
  parameter int LEN16  = 3,
  parameter int LEN_ZW = 3,
  parameter int EXT    = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       start,
  input  logic       win_sel,
  input  logic       card_is16,
  output logic       busy,
  output logic       done,
  output logic       width16
);
  localparam int MAX_A  = (LEN8 > LEN_ZW) ? LEN8 : LEN_ZW;
  localparam int MAX_B  = LEN16 + EXT;
  localparam int MAXLEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW     = $clog2(MAXLEN + 1);

  logic [CFG_W-1:0] cfg_q;
  logic [NUM_WIN-1:0] res_wide;
  logic [CW-1:0] res_len [NUM_WIN];
  logic accept;

  iowin_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata), .q(cfg_q)
  );
  assign cfg_rdata = cfg_q;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    win_ctl_t ctl;
    assign ctl = win_ctl_t'(cfg_q[w*CTL_BITS +: CTL_BITS]);
    iowin_resolve #(
      .LEN8(LEN8), .LEN16(LEN16), .LEN_ZW(LEN_ZW), .EXT(EXT), .CW(CW)
    ) u_res (
      .ctl(ctl), .card_is16(card_is16),
      .wide(res_wide[w]), .len(res_len[w])
    );
  end

  assign accept = start && !busy;

  iowin_cycle_ctr #(.CW(CW), .MAXLEN(MAXLEN)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .len_in(res_len[win_sel]), .busy(busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      width16 <= 1'b0;
    else if (accept) width16 <= res_wide[win_sel];
  end

  // R9: done lives inside busy and ends it
  a_r9_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r9_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r9_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R10: busy holds until done regardless of new starts
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R5: width fixed for the whole access
  a_r5_width_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(width16));
endmodule

// File: tb/iowin_timer_tb.sv
module iowin_timer_tb_top;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic start = 1'b0;
  logic win_sel = 1'b0;
  logic card_is16 = 1'b0;
  logic busy, done, width16;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  iowin_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .start(start), .win_sel(win_sel),
    .card_is16(card_is16), .busy(busy), .done(done), .width16(width16)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // mode: 0 none, 1 toggle card line, 2 extra start, 3 config write (wv)
  task automatic access(input bit win, input bit card, input bit exp_w,
                        input int exp_len, input int mode, input logic [7:0] wv,
                        input bit pre_wr, input logic [7:0] pre_v, input string tag);
    int n = 0;
    int dn = 0;
    int last = 0;
    @(negedge clk);
    win_sel = win; card_is16 = card; start = 1'b1;
    if (pre_wr) begin cfg_wr = 1'b1; cfg_wdata = pre_v; end
    @(negedge clk);
    start = 1'b0; cfg_wr = 1'b0;
    check(busy == 1'b1, {tag, " R9 busy rise"}, busy, 1);
    check(width16 == exp_w, {tag, " width"}, width16, exp_w);
    for (int k = 0; k < 20; k++) begin
      if (!busy) break;
      n++;
      if (done) begin dn++; last = n; end
      start  = (mode == 2) && (n == 2);
      cfg_wr = (mode == 3) && (n == 2);
      cfg_wdata = wv;
      if (mode == 1 && n >= 2) card_is16 = ~card;
      @(negedge clk);
    end
    start = 1'b0; cfg_wr = 1'b0; card_is16 = card;
    check(n == exp_len, {tag, " length"}, n, exp_len);
    check(dn == 1 && last == n, {tag, " R9 done single last"}, dn, 1);
    check(width16 == exp_w, {tag, " width held"}, width16, exp_w);
    @(negedge clk);
    check(busy == 1'b0, {tag, " R10 no follow-up"}, busy, 0);
  endtask

  task automatic t_reset();
    check(cfg_rdata == 8'h00, "R1 cfg reset", cfg_rdata, 0);
    check(busy == 1'b0, "R1 busy reset", busy, 0);
    check(done == 1'b0, "R1 done reset", done, 0);
    check(width16 == 1'b0, "R1 width reset", width16, 0);
  endtask

  task automatic t_rw();
    write_cfg(8'hA5);
    check(cfg_rdata == 8'hA5, "R2 readback A5", cfg_rdata, 8'hA5);
    write_cfg(8'h5A);
    check(cfg_rdata == 8'h5A, "R2 readback 5A", cfg_rdata, 8'h5A);
  endtask

  task automatic t_fixed();
    write_cfg(8'h00); access(0, 1, 0, 6, 0, 0, 0, 0, "R4 R6 w0 fixed8");
    write_cfg(8'h01); access(0, 0, 1, 3, 0, 0, 0, 0, "R4 R7 w0 fixed16");
  endtask

  task automatic t_stretch_shorten();
    write_cfg(8'h09); access(0, 0, 1, 4, 0, 0, 0, 0, "R7 w0 stretch16");
    write_cfg(8'h08); access(0, 0, 0, 6, 0, 0, 0, 0, "R8 stretch on 8bit");
    write_cfg(8'h04); access(0, 0, 0, 3, 0, 0, 0, 0, "R6 w0 shorten8");
    write_cfg(8'h0D); access(0, 0, 1, 4, 0, 0, 0, 0, "R8 shorten on 16bit");
  endtask

  task automatic t_source();
    write_cfg(8'h02); access(0, 1, 1, 3, 0, 0, 0, 0, "R5 card16 size0");
    write_cfg(8'h03); access(0, 0, 0, 6, 0, 0, 0, 0, "R5 card8 size1");
    write_cfg(8'h0E); access(0, 1, 1, 4, 1, 0, 0, 0, "R5 card toggles wide");
    write_cfg(8'h0E); access(0, 0, 0, 3, 1, 0, 0, 0, "R5 card toggles narrow");
  endtask

  task automatic t_window1();
    write_cfg(8'h90);
    access(1, 0, 1, 4, 0, 0, 0, 0, "R3 w1 stretch16");
    access(0, 1, 0, 6, 0, 0, 0, 0, "R3 w0 untouched");
    write_cfg(8'h64);
    access(1, 1, 1, 3, 0, 0, 0, 0, "R3 w1 card src");
    access(0, 1, 0, 3, 0, 0, 0, 0, "R3 w0 shorten");
  endtask

  task automatic t_busy_start();
    write_cfg(8'h00);
    access(0, 0, 0, 6, 2, 0, 0, 0, "R10 start while busy");
  endtask

  task automatic t_cfg_midway();
    write_cfg(8'h00);
    access(0, 0, 0, 6, 3, 8'h01, 0, 0, "R11 write mid access");
    access(0, 0, 1, 3, 0, 0, 0, 0, "R11 next uses new");
    write_cfg(8'h00);
    access(0, 0, 0, 6, 0, 0, 1, 8'h05, "R11 write with start");
    access(0, 0, 1, 3, 0, 0, 0, 0, "R11 after concurrent write");
    check(cfg_rdata == 8'h05, "R11 stored value", cfg_rdata, 5);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_fixed();
    t_stretch_shorten();
    t_source();
    t_window1();
    t_busy_start();
    t_cfg_midway();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule